// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small single-accumulator processor. A 128-word by 20-bit microcode ROM holds all of its control: a three-step fetch routine, a shared subroutine that resolves indirect operand addresses, and one microroutine for each of four machine instructions (add, branch on negative, store and exchange). Each microinstruction has three 3-bit operation fields, a 2-bit condition select, a 2-bit branch mode and a 7-bit next address. The three operation fields are decoded into register transfers among an 11-bit address register, an 11-bit program counter, a 16-bit data register, a 16-bit accumulator and a word-addressed data memory inside the block.

The memory is filled from a packed parameter image at reset, so a program is supplied when the core is instantiated. After reset the core runs on its own. The accumulator, the program counter and the current microaddress come out as observation ports, and a read-only peek port returns any memory word so that results can be inspected.

Machine words carry the indirect flag in bit 15, the opcode in bits 14..11 and the operand address in bits 10..0. Opcode 0 adds, 1 branches when the accumulator is negative, 2 stores the accumulator and 3 swaps the accumulator with memory.

Top module: `ucode_acc_core`

## Requirements
- R1: While reset is held and just after it, the microaddress is 64, the accumulator and the program counter are 0, and memory holds the parameter image (word i at address i, zero elsewhere).
- R2: Each instruction starts with three fetch cycles at microaddresses 64, 65 and 66. The program counter is incremented once during fetch. Microaddress 66 dispatches to the address opcode×4.
- R3: ADD (opcode 0000) adds M[EA] to the accumulator. With bit 15 clear it takes 6 cycles including fetch, and EA is bits 10..0 of the instruction.
- R4: With bit 15 set, the operand route first calls the indirect subroutine at 67. That subroutine makes EA equal to bits 10..0 of M[addr], adds exactly 2 cycles and returns to the step after the call.
- R5: BRANCH (opcode 0001) with accumulator bit 15 set loads the program counter with EA. This takes 6 cycles, or 8 with indirection.
- R6: BRANCH with accumulator bit 15 clear leaves the program counter at the following instruction and takes 5 cycles.
- R7: STORE (opcode 0010) writes the accumulator to M[EA]. The accumulator is unchanged, and the instruction takes 6 cycles, or 8 with indirection.
- R8: EXCHANGE (opcode 0011) leaves the old M[EA] in the accumulator and the old accumulator in M[EA]. It takes 7 cycles, or 9 with indirection.
- R9: All transfers named in one microinstruction happen on one clock edge and use the values held before that edge. The swap in R8 therefore loses neither value.
- R10: The microaddress only ever takes values from the occupied ROM words: 0-2, 4-10, 12-15 and 64-68.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; reloads memory image and registers |
| peek_addr | input | 11 | Word address for the memory observation port |
| peek_data | output | 16 | Memory word at peek_addr (combinational) |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 11 | Program counter |
| upc_o | output | 7 | Current microinstruction address |

## Verification
The embedded properties assume that the memory image is a legal program. Every word the core fetches as an instruction must use one of the four defined opcodes, because the other opcodes dispatch into empty ROM words and would trip the microaddress range property. The stimulus keeps to this by placing only valid instructions on the executed path and ending in a self-branch that loops forever with a negative accumulator. The peek port only reads, so driving it cannot disturb execution. The program mixes direct and indirect forms of every opcode, and it includes both taken and untaken branches.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

   localparam int UA_W   = 7;
   localparam int UROM_N = 1 << UA_W;

   typedef enum logic [2:0] {
      F1_NONE, F1_ACC_ADD, F1_ACC_CLR, F1_ACC_INC,
      F1_ACC_LD, F1_AR_FROM_DR, F1_AR_FROM_PC, F1_MEM_WR
   } f1_e;

   typedef enum logic [2:0] {
      F2_NONE, F2_ACC_SUB, F2_ACC_OR, F2_ACC_AND,
      F2_MEM_RD, F2_DR_FROM_ACC, F2_DR_INC, F2_DR_FROM_PC
   } f2_e;

   typedef enum logic [2:0] {
      F3_NONE, F3_ACC_XOR, F3_ACC_INV, F3_ACC_SHL,
      F3_ACC_SHR, F3_PC_INC, F3_PC_FROM_AR, F3_RSVD
   } f3_e;

   typedef enum logic [1:0] {C_ALWAYS, C_IND, C_SIGN, C_ZERO} cond_e;
   typedef enum logic [1:0] {B_GOTO, B_CALL, B_RET, B_DISPATCH} brmode_e;

   typedef struct packed {
      f1_e              f1;
      f2_e              f2;
      f3_e              f3;
      cond_e            cd;
      brmode_e          br;
      logic [UA_W-1:0]  ad;
   } uinstr_t;

   localparam logic [UA_W-1:0] UA_FETCH = 7'd64;
   localparam logic [UA_W-1:0] UA_INDIR = 7'd67;

   function automatic uinstr_t mk(f1_e a, f2_e b, f3_e c, cond_e d, brmode_e e,
                                  logic [UA_W-1:0] t);
      uinstr_t u;
      u.f1 = a; u.f2 = b; u.f3 = c; u.cd = d; u.br = e; u.ad = t;
      return u;
   endfunction

endpackage

// File: rtl/uc_rom.sv
module uc_rom
   import ucode_pkg::*;
(
   input  logic [UA_W-1:0] uaddr,
   output uinstr_t         uword
);
   always_comb begin
      unique case (uaddr)
         // add
         7'd0:  uword = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, UA_INDIR);
         7'd1:  uword = mk(F1_NONE, F2_MEM_RD, F3_NONE, C_ALWAYS, B_GOTO, 7'd2);
         7'd2:  uword = mk(F1_ACC_ADD, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, UA_FETCH);
         // branch on negative
         7'd4:  uword = mk(F1_NONE, F2_NONE, F3_NONE, C_SIGN, B_GOTO, 7'd6);
         7'd5:  uword = mk(F1_NONE, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, UA_FETCH);
         7'd6:  uword = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, UA_INDIR);
         7'd7:  uword = mk(F1_NONE, F2_NONE, F3_PC_FROM_AR, C_ALWAYS, B_GOTO, UA_FETCH);
         // store
         7'd8:  uword = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, UA_INDIR);
         7'd9:  uword = mk(F1_NONE, F2_DR_FROM_ACC, F3_NONE, C_ALWAYS, B_GOTO, 7'd10);
         7'd10: uword = mk(F1_MEM_WR, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, UA_FETCH);
         // exchange
         7'd12: uword = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, UA_INDIR);
         7'd13: uword = mk(F1_NONE, F2_MEM_RD, F3_NONE, C_ALWAYS, B_GOTO, 7'd14);
         7'd14: uword = mk(F1_ACC_LD, F2_DR_FROM_ACC, F3_NONE, C_ALWAYS, B_GOTO, 7'd15);
         7'd15: uword = mk(F1_MEM_WR, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, UA_FETCH);
         // fetch
         7'd64: uword = mk(F1_AR_FROM_PC, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, 7'd65);
         7'd65: uword = mk(F1_NONE, F2_MEM_RD, F3_PC_INC, C_ALWAYS, B_GOTO, 7'd66);
         7'd66: uword = mk(F1_AR_FROM_DR, F2_NONE, F3_NONE, C_ALWAYS, B_DISPATCH, 7'd0);
         // indirect resolve
         7'd67: uword = mk(F1_NONE, F2_MEM_RD, F3_NONE, C_ALWAYS, B_GOTO, 7'd68);
         7'd68: uword = mk(F1_AR_FROM_DR, F2_NONE, F3_NONE, C_ALWAYS, B_RET, 7'd0);
         default: uword = mk(F1_NONE, F2_NONE, F3_NONE, C_ALWAYS, B_GOTO, UA_FETCH);
      endcase
   end
endmodule

// File: rtl/uc_seq.sv
module uc_seq
   import ucode_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  uinstr_t         uword,
   input  logic            ind_bit,
   input  logic            acc_neg,
   input  logic            acc_zero,
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] upc_q
);
   localparam int PAD_W = UA_W - OP_W - 2;

   logic [UA_W-1:0] sbr_q, upc_n, sbr_n, upc_inc;
   logic            take;

   assign upc_inc = upc_q + 1'b1;

   always_comb begin
      unique case (uword.cd)
         C_ALWAYS: take = 1'b1;
         C_IND:    take = ind_bit;
         C_SIGN:   take = acc_neg;
         default:  take = acc_zero;
      endcase
   end

   always_comb begin
      upc_n = upc_inc;
      sbr_n = sbr_q;
      unique case (uword.br)
         B_GOTO: if (take) upc_n = uword.ad;
         B_CALL: if (take) begin
            upc_n = uword.ad;
            sbr_n = upc_inc;
         end
         B_RET:  upc_n = sbr_q;
         default: upc_n = {{PAD_W{1'b0}}, opcode, 2'b00};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upc_q <= UA_FETCH;
         sbr_q <= '0;
      end else begin
         upc_q <= upc_n;
         sbr_q <= sbr_n;
      end
   end

   // R10
   valid_upc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upc_q inside {[7'd0:7'd2], [7'd4:7'd10], [7'd12:7'd15], [7'd64:7'd68]});

   // R2
   dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc_q == 7'd66) |=> (upc_q[1:0] == 2'b00 && upc_q < 7'd16));

   // R4
   indir_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc_q == 7'd68) |=> (upc_q inside {7'd1, 7'd7, 7'd9, 7'd13}));
endmodule

// File: rtl/uc_dp.sv
module uc_dp
   import ucode_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 11,
   parameter int MEM_DEPTH = 2048,
   parameter int IMG_WORDS = 1,
   parameter logic [IMG_WORDS*DATA_W-1:0] INIT_IMG = '0,
   parameter bit SHR_ARITH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  f1_e               f1,
   input  f2_e               f2,
   input  f3_e               f3,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] dr_q,
   output logic [ADDR_W-1:0] ar_q,
   output logic [ADDR_W-1:0] pc_q
);
   localparam int IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

   logic [DATA_W-1:0] mem [MEM_DEPTH];
   logic [DATA_W-1:0] acc_n, dr_n, rd_word, shr_val;
   logic [ADDR_W-1:0] ar_n, pc_n;
   logic [IDX_W-1:0]  ar_idx;
   logic              mem_we;

   assign ar_idx    = ar_q[IDX_W-1:0];
   assign rd_word   = mem[ar_idx];
   assign peek_data = mem[peek_addr[IDX_W-1:0]];
   assign mem_we    = (f1 == F1_MEM_WR);

   generate
      if (SHR_ARITH) begin : g_shr_arith
         assign shr_val = {acc_q[DATA_W-1], acc_q[DATA_W-1:1]};
      end else begin : g_shr_logic
         assign shr_val = {1'b0, acc_q[DATA_W-1:1]};
      end
   endgenerate

   always_comb begin
      acc_n = acc_q;
      dr_n  = dr_q;
      ar_n  = ar_q;
      pc_n  = pc_q;
      unique case (f1)
         F1_ACC_ADD:    acc_n = acc_q + dr_q;
         F1_ACC_CLR:    acc_n = '0;
         F1_ACC_INC:    acc_n = acc_q + 1'b1;
         F1_ACC_LD:     acc_n = dr_q;
         F1_AR_FROM_DR: ar_n  = dr_q[ADDR_W-1:0];
         F1_AR_FROM_PC: ar_n  = pc_q;
         default: ;
      endcase
      unique case (f2)
         F2_ACC_SUB:     acc_n = acc_q - dr_q;
         F2_ACC_OR:      acc_n = acc_q | dr_q;
         F2_ACC_AND:     acc_n = acc_q & dr_q;
         F2_MEM_RD:      dr_n  = rd_word;
         F2_DR_FROM_ACC: dr_n  = acc_q;
         F2_DR_INC:      dr_n  = dr_q + 1'b1;
         F2_DR_FROM_PC:  dr_n  = {dr_q[DATA_W-1:ADDR_W], pc_q};
         default: ;
      endcase
      unique case (f3)
         F3_ACC_XOR:    acc_n = acc_q ^ dr_q;
         F3_ACC_INV:    acc_n = ~acc_q;
         F3_ACC_SHL:    acc_n = {acc_q[DATA_W-2:0], 1'b0};
         F3_ACC_SHR:    acc_n = shr_val;
         F3_PC_INC:     pc_n  = pc_q + 1'b1;
         F3_PC_FROM_AR: pc_n  = ar_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         dr_q  <= '0;
         ar_q  <= '0;
         pc_q  <= '0;
      end else begin
         acc_q <= acc_n;
         dr_q  <= dr_n;
         ar_q  <= ar_n;
         pc_q  <= pc_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
         for (int i = 0; i < IMG_WORDS; i++) mem[i] <= INIT_IMG[i*DATA_W +: DATA_W];
      end else if (mem_we) begin
         mem[ar_idx] <= dr_q;
      end
   end

   // R9
   swap_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f1 == F1_ACC_LD && f2 == F2_DR_FROM_ACC)
      |=> (acc_q == $past(dr_q) && dr_q == $past(acc_q)));

   // R7
   mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem[$past(ar_idx)] == $past(dr_q)));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f3 == F3_PC_INC) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/ucode_acc_core.sv
module ucode_acc_core
   import ucode_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 11,
   parameter int MEM_DEPTH = 2048,
   parameter int IMG_WORDS = 1,
   parameter logic [IMG_WORDS*DATA_W-1:0] INIT_IMG = '0,
   parameter bit SHR_ARITH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] acc_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [UA_W-1:0]   upc_o
);
   localparam int OP_W = DATA_W - ADDR_W - 1;

   if (OP_W != 4) begin : g_bad_split
      $error("DATA_W must equal ADDR_W + 5 (indirect bit and 4-bit opcode)");
   end
   if (MEM_DEPTH > (1 << ADDR_W) || MEM_DEPTH < 2) begin : g_bad_depth
      $error("MEM_DEPTH must lie in 2 .. 2**ADDR_W");
   end
   if (IMG_WORDS > MEM_DEPTH) begin : g_bad_img
      $error("IMG_WORDS exceeds MEM_DEPTH");
   end

   uinstr_t           uword;
   logic [UA_W-1:0]   upc_q;
   logic [DATA_W-1:0] acc_q, dr_q;
   logic [ADDR_W-1:0] ar_q, pc_q;

   uc_rom u_rom (
      .uaddr (upc_q),
      .uword (uword)
   );

   uc_seq #(.OP_W(OP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .uword    (uword),
      .ind_bit  (dr_q[DATA_W-1]),
      .acc_neg  (acc_q[DATA_W-1]),
      .acc_zero (acc_q == '0),
      .opcode   (dr_q[DATA_W-2:ADDR_W]),
      .upc_q    (upc_q)
   );

   uc_dp #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .MEM_DEPTH (MEM_DEPTH),
      .IMG_WORDS (IMG_WORDS),
      .INIT_IMG  (INIT_IMG),
      .SHR_ARITH (SHR_ARITH)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .f1        (uword.f1),
      .f2        (uword.f2),
      .f3        (uword.f3),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .acc_q     (acc_q),
      .dr_q      (dr_q),
      .ar_q      (ar_q),
      .pc_q      (pc_q)
   );

   assign acc_o = acc_q;
   assign pc_o  = pc_q;
   assign upc_o = upc_q;

   // R5
   branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc_q == 7'd7) |=> (pc_q == $past(ar_q)));

   // R6
   branch_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc_q == 7'd5) |=> (upc_q == UA_FETCH && $stable(pc_q)));
endmodule

// File: tb/ucode_acc_core_bench.sv
`timescale 1ns/1ps
module ucode_acc_core_bench;
   localparam int IMGW = 32;

   function automatic logic [IMGW*16-1:0] build_img();
      logic [15:0] w [IMGW];
      logic [IMGW*16-1:0] v;
      for (int i = 0; i < IMGW; i++) w[i] = 16'h0000;
      w[0]  = 16'h0014; w[1]  = 16'h8015; w[2]  = 16'h1017; w[3]  = 16'h1818;
      w[4]  = 16'h0807; w[5]  = 16'h0014; w[7]  = 16'h9819; w[8]  = 16'h081E;
      w[9]  = 16'h901B; w[10] = 16'h1818; w[11] = 16'h001D; w[12] = 16'h881F;
      w[20] = 16'd5;    w[21] = 16'd22;   w[22] = 16'd7;    w[24] = 16'hFFF0;
      w[25] = 16'd26;   w[26] = 16'd3;    w[27] = 16'd28;   w[29] = 16'h8000;
      w[31] = 16'd12;
      for (int i = 0; i < IMGW; i++) v[i*16 +: 16] = w[i];
      return v;
   endfunction

   localparam logic [IMGW*16-1:0] IMG = build_img();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] peek_addr = '0;
   logic [15:0] peek_data, acc_o;
   logic [10:0] pc_o;
   logic [6:0]  upc_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] mm [2048];
   logic [15:0] m_acc;
   logic [10:0] m_pc;
   string       tag;

   always #5 clk = ~clk;

   ucode_acc_core #(.IMG_WORDS(IMGW), .INIT_IMG(IMG)) u_ucode_acc_core (
      .clk (clk), .rst_n (rst_n), .peek_addr (peek_addr), .peek_data (peek_data),
      .acc_o (acc_o), .pc_o (pc_o), .upc_o (upc_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // executes one machine instruction in the model, returns cycle count
   function automatic int step();
      logic [15:0] w, t;
      logic [10:0] ea;
      int len;
      w = mm[m_pc];
      m_pc = m_pc + 11'd1;
      ea = w[10:0];
      len = 3;
      tag = "";
      case (w[14:11])
         4'd0: begin
            if (w[15]) begin ea = mm[ea][10:0]; len += 2; tag = "R4 "; end
            m_acc = m_acc + mm[ea]; len += 3; tag = {tag, "R3 R2"};
         end
         4'd1: begin
            if (m_acc[15]) begin
               if (w[15]) begin ea = mm[ea][10:0]; len += 2; tag = "R4 "; end
               m_pc = ea; len += 3; tag = {tag, "R5 R2"};
            end else begin
               len += 2; tag = "R6 R2";
            end
         end
         4'd2: begin
            if (w[15]) begin ea = mm[ea][10:0]; len += 2; tag = "R4 "; end
            mm[ea] = m_acc; len += 3; tag = {tag, "R7 R2"};
         end
         default: begin
            if (w[15]) begin ea = mm[ea][10:0]; len += 2; tag = "R4 "; end
            t = mm[ea]; mm[ea] = m_acc; m_acc = t; len += 4; tag = {tag, "R8 R9 R2"};
         end
      endcase
      return len;
   endfunction

   function automatic bit legal_upc(input logic [6:0] u);
      return (u <= 7'd2) || (u >= 7'd4 && u <= 7'd10) ||
             (u >= 7'd12 && u <= 7'd15) || (u >= 7'd64 && u <= 7'd68);
   endfunction

   initial begin
      int nb;
      for (int i = 0; i < 2048; i++) mm[i] = 16'h0000;
      for (int i = 0; i < IMGW; i++) mm[i] = IMG[i*16 +: 16];
      m_acc = '0;
      m_pc  = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "upc in reset", upc_o, 64);
      chk("R1", "acc in reset", acc_o, 0);
      chk("R1", "pc in reset", pc_o, 0);
      peek_addr = 11'd24; #1;
      chk("R1", "image word 24", peek_data, 16'hFFF0);
      peek_addr = 11'd40; #1;
      chk("R1", "word beyond image", peek_data, 0);
      peek_addr = '0;
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      nb = 0;
      for (int k = 0; k < 220; k++) begin
         // R10 microaddress range
         chk("R10", "legal microaddress", legal_upc(upc_o), 1);
         if (k == nb) begin
            chk(tag, "boundary at fetch", upc_o, 64);
            chk(tag, "acc at boundary", acc_o, m_acc);
            chk(tag, "pc at boundary", pc_o, m_pc);
            nb = nb + step();
         end else begin
            chk(tag, "not at fetch between boundaries", upc_o == 7'd64, 0);
         end
         @(negedge clk);
      end
      // R7 R8 final memory
      for (int a = 0; a < IMGW; a++) begin
         peek_addr = 11'(a); #1;
         chk("R7 R8", $sformatf("memory word %0d", a), peek_data, mm[a]);
      end
      peek_addr = 11'd23; #1;
      chk("R7", "stored word 23", peek_data, 12);
      peek_addr = 11'd26; #1;
      chk("R8", "exchanged word 26", peek_data, 16'hFFF0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule